// File: doc/BRIEF.md
# DC-Balanced Video/Control Word Framer

This block sits between a pixel-rate source and a serial line driver. It runs on a single bit-rate clock and divides it internally by twenty to get a word strobe. At each strobe it captures one parallel beat. A beat holds 18 video bits, 9 control bits and a data-enable flag. From each captured beat it forms one 20-bit line word and shifts that word out least-significant bit first, one bit per clock. A marker output is high while bit 0 of a word is on the line. The source changes its beat once per marker and holds it steady until the next strobe.

With data-enable high, the block sends a video word. The 18 data bits are kept as they are or inverted so that a running disparity stays small, and a flag bit in the word records which choice was made. With data-enable low, the block sends a control word. Each of the five low control bits is repeated three times, so a receiver can vote on them, and the four upper control bits are sent once each.

Every captured beat waits two word slots in a delay line, so the framer can see upcoming data-enable edges. Any low-enable slot that lies within two slots of a high-enable slot, on either side, carries a fixed transition word instead of control data. Control values offered in those slots are dropped.

Top module: `dcf_framer`

## Requirements
- R1: `ser_frame` is high for exactly one clock in every 20, starting in the first clock after reset. The 20 line bits that start at a marker form one word, sent bit 0 first.
- R2: A beat with enable high gives a video word. Bit 0 is 1, bit 1 is the inversion flag, and bits 2..19 hold the 18 video bits in order (video bit k in line bit k+2), inverted when the flag is 1.
- R3: Disparity of a beat is d = 2·(ones in the 18 video bits) − 18. The running disparity starts at 0 and changes only on video words. The video bits are inverted when d and the running disparity are both nonzero and have the same sign; the running disparity then adds −d, and otherwise adds d. Its magnitude never exceeds 18.
- R4: A beat with enable low that is outside every transition window gives a control word. Bit 0 is 0, line bits 3i+1..3i+3 all equal control bit i for i = 0..4, and line bits 16..19 carry control bits 5..8.
- R5: A beat with enable low gives the transition word 20'hAAAAA when either of the two beats before it, or either of the two beats after it, has enable high.
- R6: The control bits of beats with enable high, or of beats inside a transition window, have no effect on the line. The video bits of beats with enable low have no effect on the line.
- R7: The beat captured at strobe k goes out, bit 0 first, in the word that follows strobe k+2.
- R8: During reset and until the first word loads, `ser_out` is 0. The pipeline resets to enable-low, all-zero beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_rgb | input | 18 | Video bits of the current beat |
| pix_ctl | input | 9 | Control bits of the current beat |
| pix_de | input | 1 | Data-enable of the current beat |
| ser_out | output | 1 | Serial line bit |
| ser_frame | output | 1 | High while bit 0 of a word is on `ser_out` |

## Verification
The hardest cases to reach are the short low-enable gaps. A gap of one to four beats is covered entirely by overlapping transition windows, so it never carries a control word, while a gap of five or more leaves some control slots open. The stimulus walks through gaps of every length from 1 to 8 and changes the control bits on every beat, so any control value leaking into a reserved slot shows up on the line. The video runs include all-ones and all-zeros beats and long runs of same-sign disparity, which push the running disparity to its limits and exercise the inversion decision on both signs.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    localparam int WORD_W   = 20;
    localparam int VID_W    = 18;
    localparam int CTL_W    = 9;
    localparam int TRIP_N   = 5;
    localparam int SINGLE_N = CTL_W - TRIP_N;
    localparam int CNT_W    = $clog2(WORD_W);
    localparam int RD_W     = 8;
    localparam int RD_LIMIT = VID_W;
    localparam logic [WORD_W-1:0] TRANS_WORD = 20'hAAAAA;

    typedef struct packed {
        logic             de;
        logic [VID_W-1:0] rgb;
        logic [CTL_W-1:0] ctl;
    } beat_t;

    typedef enum logic [1:0] {
        KIND_CTL = 2'd0,
        KIND_VID = 2'd1,
        KIND_TRN = 2'd2
    } kind_e;
endpackage

// File: rtl/dcf_tick.sv
module dcf_tick
    import dcf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic strobe,
    output logic first_bit
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tick_t;

    tick_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == CNT_W'(WORD_W - 1)) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe    = (st_q.cnt == CNT_W'(WORD_W - 1));
    assign first_bit = (st_q.cnt == '0);
endmodule

// File: rtl/dcf_lookahead.sv
module dcf_lookahead
    import dcf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  strobe,
    input  beat_t beat_i,
    output beat_t cur_o,
    output logic  ahead1_de,
    output logic  back1_de,
    output logic  back2_de
);
    typedef struct packed {
        beat_t near_s;
        beat_t cur_s;
        logic  back1;
        logic  back2;
    } look_t;

    look_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (strobe) begin
            st_d.near_s = beat_i;
            st_d.cur_s  = st_q.near_s;
            st_d.back1  = st_q.cur_s.de;
            st_d.back2  = st_q.back1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_o     = st_q.cur_s;
    assign ahead1_de = st_q.near_s.de;
    assign back1_de  = st_q.back1;
    assign back2_de  = st_q.back2;
endmodule

// File: rtl/dcf_encoder.sv
module dcf_encoder
    import dcf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  beat_t             cur_i,
    input  logic              ahead1_de,
    input  logic              ahead2_de,
    input  logic              back1_de,
    input  logic              back2_de,
    output logic [WORD_W-1:0] word_o,
    output kind_e             kind_o,
    output logic [RD_W-1:0]   rd_o
);
    typedef struct packed {
        logic [RD_W-1:0] rd;
    } enc_t;

    enc_t st_d, st_q;

    logic [WORD_W-1:0] ctl_word;
    logic [WORD_W-1:0] vid_word;
    logic              invert;
    int                disp;
    int                rd_now;

    assign ctl_word[0] = 1'b0;
    for (genvar i = 0; i < TRIP_N; i++) begin : g_trip
        assign ctl_word[1 + 3*i +: 3] = {3{cur_i.ctl[i]}};
    end
    for (genvar j = 0; j < SINGLE_N; j++) begin : g_single
        assign ctl_word[1 + 3*TRIP_N + j] = cur_i.ctl[TRIP_N + j];
    end

    always_comb begin
        int ones;
        ones = 0;
        for (int k = 0; k < VID_W; k++) begin
            ones = ones + int'(cur_i.rgb[k]);
        end
        disp   = 2 * ones - VID_W;
        rd_now = int'(signed'(st_q.rd));
        invert = ((rd_now > 0) && (disp > 0)) || ((rd_now < 0) && (disp < 0));
        vid_word = {(invert ? ~cur_i.rgb : cur_i.rgb), invert, 1'b1};
    end

    always_comb begin
        st_d = st_q;
        if (cur_i.de) begin
            kind_o = KIND_VID;
            word_o = vid_word;
        end else if (ahead1_de || ahead2_de || back1_de || back2_de) begin
            kind_o = KIND_TRN;
            word_o = TRANS_WORD;
        end else begin
            kind_o = KIND_CTL;
            word_o = ctl_word;
        end
        if (strobe && cur_i.de) begin
            st_d.rd = RD_W'(invert ? (rd_now - disp) : (rd_now + disp));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_o = st_q.rd;
endmodule

// File: rtl/dcf_piso.sv
module dcf_piso
    import dcf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [WORD_W-1:0] word_i,
    output logic              ser_o
);
    typedef struct packed {
        logic [WORD_W-1:0] sh;
    } piso_t;

    piso_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (strobe) begin
            st_d.sh = word_i;
        end else begin
            st_d.sh = {1'b0, st_q.sh[WORD_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_o = st_q.sh[0];
endmodule

// File: rtl/dcf_framer.sv
module dcf_framer
    import dcf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VID_W-1:0] pix_rgb,
    input  logic [CTL_W-1:0] pix_ctl,
    input  logic             pix_de,
    output logic             ser_out,
    output logic             ser_frame
);
    logic              strobe;
    beat_t             live_beat;
    beat_t             cur_beat;
    logic              ahead1_de;
    logic              back1_de;
    logic              back2_de;
    logic [WORD_W-1:0] word_w;
    kind_e             kind_w;
    logic [RD_W-1:0]   rd_w;

    assign live_beat = '{de: pix_de, rgb: pix_rgb, ctl: pix_ctl};

    dcf_tick u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (strobe),
        .first_bit (ser_frame)
    );

    dcf_lookahead u_look (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (strobe),
        .beat_i    (live_beat),
        .cur_o     (cur_beat),
        .ahead1_de (ahead1_de),
        .back1_de  (back1_de),
        .back2_de  (back2_de)
    );

    dcf_encoder u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (strobe),
        .cur_i     (cur_beat),
        .ahead1_de (ahead1_de),
        .ahead2_de (pix_de),
        .back1_de  (back1_de),
        .back2_de  (back2_de),
        .word_o    (word_w),
        .kind_o    (kind_w),
        .rd_o      (rd_w)
    );

    dcf_piso u_piso (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe),
        .word_i (word_w),
        .ser_o  (ser_out)
    );
endmodule

// File: rtl/dcf_framer_chk.sv
module dcf_framer_chk
    import dcf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ser_frame,
    input logic              strobe,
    input logic [WORD_W-1:0] word,
    input kind_e             kind,
    input logic [RD_W-1:0]   rd
);
    logic [CNT_W-1:0] gap_q;
    logic             seen_q;
    kind_e            prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
            prev_q <= KIND_CTL;
        end else begin
            if (ser_frame) begin
                gap_q  <= '0;
                seen_q <= 1'b1;
            end else begin
                gap_q <= gap_q + 1'b1;
            end
            if (strobe) begin
                prev_q <= kind;
            end
        end
    end

    // R1
    frame_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_frame && seen_q) |-> (gap_q == CNT_W'(WORD_W - 1)));

    // R1
    frame_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_frame |=> !ser_frame);

    // R2
    video_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && kind == KIND_VID) |-> word[0]);

    // R4
    ctl_vote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && kind == KIND_CTL) |->
        (!word[0] && word[1] == word[2] && word[2] == word[3] &&
         word[13] == word[14] && word[14] == word[15]));

    // R5
    no_vid_after_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && kind == KIND_VID) |-> (prev_q != KIND_CTL));

    // R5
    no_ctl_after_vid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && kind == KIND_CTL) |-> (prev_q != KIND_VID));

    // R3
    rd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(signed'(rd)) <= RD_LIMIT) && (int'(signed'(rd)) >= -RD_LIMIT));
endmodule

bind dcf_framer dcf_framer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_frame (ser_frame),
    .strobe    (strobe),
    .word      (word_w),
    .kind      (kind_w),
    .rd        (rd_w)
);

// File: tb/dcf_framer_bench.sv
module dcf_framer_bench;
    localparam int N = 96;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] pix_rgb = '0;
    logic [8:0]  pix_ctl = '0;
    logic        pix_de = 1'b0;
    logic        ser_out;
    logic        ser_frame;

    always #2 clk = ~clk;

    dcf_framer u_dcf_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_rgb   (pix_rgb),
        .pix_ctl   (pix_ctl),
        .pix_de    (pix_de),
        .ser_out   (ser_out),
        .ser_frame (ser_frame)
    );

    logic        de_a  [0:N+3];
    logic [17:0] rgb_a [0:N+3];
    logic [8:0]  ctl_a [0:N+3];
    logic [19:0] exp_a [0:N+3];
    string       tag_a [0:N+3];

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seg_len [0:15] = '{6, 5, 1, 3, 2, 1, 3, 4, 4, 6, 5, 2, 7, 3, 8, 9};
        int idx;
        int seg;
        logic cur_de;
        int lcg;
        int rd;
        int f;
        int bitpos;
        int gap;
        logic [19:0] got;

        for (int i = 0; i < N + 4; i++) begin
            de_a[i] = 1'b0; rgb_a[i] = '0; ctl_a[i] = '0;
        end
        idx = 2; seg = 0; cur_de = 1'b0; lcg = 32'h1234_5678;
        while (idx < N + 4) begin
            for (int k = 0; k < seg_len[seg % 16] && idx < N + 4; k++) begin
                lcg = lcg * 1103515245 + 12345;
                de_a[idx]  = cur_de;
                rgb_a[idx] = 18'(lcg >>> 7);
                ctl_a[idx] = 9'(lcg >>> 3);
                if (idx % 11 == 0) rgb_a[idx] = '1;
                if (idx % 13 == 0) rgb_a[idx] = '0;
                if (idx >= 40 && idx < 52 && cur_de) rgb_a[idx] = 18'h3FFF0;
                idx++;
            end
            cur_de = ~cur_de;
            seg++;
        end

        // behavioural model of the line word for each slot
        rd = 0;
        for (int s = 0; s < N + 2; s++) begin
            if (de_a[s]) begin
                int d;
                logic inv;
                d = 2 * $countones(rgb_a[s]) - 18;
                inv = (rd > 0 && d > 0) || (rd < 0 && d < 0);
                exp_a[s] = {(inv ? ~rgb_a[s] : rgb_a[s]), inv, 1'b1};
                rd = inv ? rd - d : rd + d;
                tag_a[s] = "R2 R3 R6 R1 R7";
                if (rd > 18 || rd < -18) $display("model disparity out of range");
            end else if ((s >= 1 && de_a[s-1]) || (s >= 2 && de_a[s-2]) ||
                         de_a[s+1] || de_a[s+2]) begin
                exp_a[s] = 20'hAAAAA;
                tag_a[s] = "R5 R6 R1 R7";
            end else begin
                exp_a[s] = '0;
                for (int c = 0; c < 5; c++) begin
                    exp_a[s][1+3*c] = ctl_a[s][c];
                    exp_a[s][2+3*c] = ctl_a[s][c];
                    exp_a[s][3+3*c] = ctl_a[s][c];
                end
                for (int c = 0; c < 4; c++) exp_a[s][16+c] = ctl_a[s][5+c];
                tag_a[s] = (s < 2) ? "R8 R4 R1 R7" : "R4 R6 R1 R7";
            end
        end

        repeat (3) @(negedge clk);
        // R8: reset state of the line
        checks++;
        if (ser_out !== 1'b0) begin
            errors++;
            $display("FAIL R8 reset ser_out actual %b expected 0", ser_out);
        end
        rst_n = 1'b1;

        f = -2; bitpos = 0; got = '0; gap = 0;
        while (f < N) begin
            if (ser_frame) begin
                if (f == -1) begin
                    checks++;
                    if (got !== 20'h0) begin
                        errors++;
                        $display("FAIL R8 first word actual %h expected %h", got, 20'h0);
                    end
                end else if (f >= 0) begin
                    checks++;
                    if (got !== exp_a[f]) begin
                        errors++;
                        $display("FAIL %s slot %0d actual %h expected %h",
                                 tag_a[f], f, got, exp_a[f]);
                    end
                end
                if (f >= -1) begin
                    checks++;
                    if (gap != 20) begin
                        errors++;
                        $display("FAIL R1 marker spacing actual %0d expected 20", gap);
                    end
                end
                f++;
                gap = 0;
                bitpos = 0;
                got = '0;
                if (f + 3 <= N + 3) begin
                    pix_de  = de_a[f+3];
                    pix_rgb = rgb_a[f+3];
                    pix_ctl = ctl_a[f+3];
                end
            end
            if (bitpos < 20) got[bitpos] = ser_out;
            bitpos++;
            gap++;
            @(negedge clk);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule